// File: doc/BRIEF.md
# Virtual Timer Compare Access Router

This block decides what happens when software at a given privilege level reads or writes the virtual timer compare value. Each request carries the current level (0 to 3) and a set of control bits. These bits give the execution width of levels 1 and 2, whether level 2 is enabled, the two hypervisor routing bits (host-extension and trap-general), the security state, whether a secure level 2 is implemented, the three user-access enables and the level-1 virtual-timer trap bit held at level 2. The block walks a fixed priority chain and produces one verdict for the access:

- allow it;
- trap it to level 1;
- trap it to level 2;
- raise a hypervisor trap;
- treat it as undefined.

For allowed accesses it also names which of three physical compare registers the access is steered to. When level 2 runs in host mode, an allowed level-0 access goes to a hypervisor-owned register, and the secure and non-secure states get different registers.

Reads and writes follow the same chain. The direction bit only travels alongside the verdict. The decision logic is purely combinational. A parameter selects whether the result is captured in an output register, which gives one cycle of latency, or presented in the same cycle. Carrying out the access itself is left to the requester.

Top module: `ttr_access_router`

## Requirements
- R1: During and right after reset, `rsp_vld` is 0, `rsp_act` is 0, `rsp_tgt` is 3 and `rsp_syn` is 0.
- R2: With the output register present (default), the verdict, `rsp_vld` and `rsp_wr` for a request appear on the cycle after it is presented. When `req_vld` is 0, `rsp_vld` is 0 on the next cycle.
- R3: At levels 2 and 3 (`req_lvl` 2 or 3) every access is allowed (action 0) and targets the normal virtual compare register (target 0), whatever the control bits.
- R4: At level 1, the access traps to level 2 (action 2) when level 2 is enabled, 64-bit, and `l1_vt_trap` is 1. Otherwise it is allowed to target 0.
- R5: At level 0, with level 1 in 64-bit state, host mode inactive and `usr_vt_en_l1a64` at 0, the access traps. It goes to level 2 (action 2) if level 2 is enabled, 64-bit and `hv_tge` is 1. Otherwise it goes to level 1 (action 1).
- R6: At level 0, with level 1 in 32-bit state and `usr_vt_en_l1a32` at 0, the outcome depends on level 2. If level 2 is enabled, 64-bit and trap-general is set, the access traps to level 2. If level 2 is enabled, 32-bit and trap-general is set, it raises a hypervisor trap (action 3). Otherwise it is undefined (action 4).
- R7: Host mode means level 2 is enabled and 64-bit, and `hv_e2h` and `hv_tge` are both 1. At level 0 in host mode with `usr_vt_en_l2` at 0, the access traps to level 2, unless R5 or R6 applied first.
- R8: At level 0 outside host mode, with level 2 enabled and 64-bit and `l1_vt_trap` at 1, the access traps to level 2. Earlier rules take precedence.
- R9: An allowed level-0 access in host mode is steered by security state. With `nonsec`=0 and `sec_l2_impl`=1 it goes to target 1 (secure hypervisor compare). With `nonsec`=1 it goes to target 2 (non-secure hypervisor compare). Otherwise it goes to target 0.
- R10: Any action other than allow gives target 3 (none). The syndrome is 0x04 for actions 1 and 2 and 0x00 for every other action.
- R11: `rsp_wr` echoes `req_wr`, and the verdict is the same for a read and a write with equal control inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request present |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_lvl | input | 2 | Current privilege level |
| l1_aa64 | input | 1 | Level 1 in 64-bit state |
| l2_aa64 | input | 1 | Level 2 in 64-bit state |
| l2_on | input | 1 | Level 2 enabled |
| hv_e2h | input | 1 | Hypervisor host-extension bit |
| hv_tge | input | 1 | Hypervisor trap-general bit |
| nonsec | input | 1 | 1 = non-secure state |
| sec_l2_impl | input | 1 | Secure level 2 implemented |
| usr_vt_en_l1a64 | input | 1 | Level-0 timer enable, level-1 64-bit control |
| usr_vt_en_l1a32 | input | 1 | Level-0 timer enable, level-1 32-bit control |
| usr_vt_en_l2 | input | 1 | Level-0 timer enable, level-2 control |
| l1_vt_trap | input | 1 | Level-2 trap bit for lower-level virtual timer access |
| rsp_vld | output | 1 | Verdict valid |
| rsp_wr | output | 1 | Echoed direction |
| rsp_act | output | 3 | Action code |
| rsp_tgt | output | 2 | Target register select |
| rsp_syn | output | SYN_W | Syndrome value |

## Verification
Several rules of the chain can be met by the same input vector in the same cycle, and the verdict is correct only if the earlier rule wins. For example, a 32-bit level 1 with its user enable clear while the level-2 trap bit is also set must resolve by R6, not R8. Likewise, host mode with a clear level-2 user enable must trap and never be steered. These collisions are provoked by directed vectors that set both conditions together, and then by an exhaustive sweep of every level and control-bit combination. Each response is judged against a reference model in the bench that encodes the rules in requirement order.

// File: rtl/ttr_pkg.sv
package ttr_pkg;

    typedef enum logic [2:0] {
        ACT_ALLOW   = 3'd0,
        ACT_TRAP_L1 = 3'd1,
        ACT_TRAP_L2 = 3'd2,
        ACT_HYP     = 3'd3,
        ACT_UNDEF   = 3'd4
    } ttr_act_e;

    typedef enum logic [1:0] {
        TGT_VIRT   = 2'd0,
        TGT_HV_SEC = 2'd1,
        TGT_HV_NS  = 2'd2,
        TGT_NONE   = 2'd3
    } ttr_tgt_e;

    typedef struct packed {
        ttr_act_e act;
        ttr_tgt_e tgt;
    } ttr_dec_t;

    localparam ttr_dec_t DEC_ALLOW_VIRT = '{act: ACT_ALLOW, tgt: TGT_VIRT};

endpackage

// File: rtl/ttr_mode_decode.sv
module ttr_mode_decode (
    input  logic l2_on,
    input  logic l2_aa64,
    input  logic hv_e2h,
    input  logic hv_tge,
    output logic l2_a64_on,
    output logic host,
    output logic l2_a64_tge,
    output logic l2_a32_tge,
    output logic l2_a64_nohost
);
    always_comb begin
        l2_a64_on     = l2_on && l2_aa64;
        host          = l2_a64_on && hv_e2h && hv_tge;
        l2_a64_tge    = l2_a64_on && hv_tge;
        l2_a32_tge    = l2_on && !l2_aa64 && hv_tge;
        l2_a64_nohost = l2_a64_on && !(hv_e2h && hv_tge);
    end
endmodule

// File: rtl/ttr_user_chain.sv
module ttr_user_chain
    import ttr_pkg::*;
(
    input  logic     l1_aa64,
    input  logic     usr_en_l1a64,
    input  logic     usr_en_l1a32,
    input  logic     usr_en_l2,
    input  logic     l1_vt_trap,
    input  logic     nonsec,
    input  logic     sec_l2_impl,
    input  logic     host,
    input  logic     l2_a64_tge,
    input  logic     l2_a32_tge,
    input  logic     l2_a64_nohost,
    output ttr_dec_t dec
);
    always_comb begin
        dec = DEC_ALLOW_VIRT;
        if (l1_aa64 && !host && !usr_en_l1a64) begin
            dec.tgt = TGT_NONE;
            dec.act = l2_a64_tge ? ACT_TRAP_L2 : ACT_TRAP_L1;
        end else if (!l1_aa64 && !usr_en_l1a32) begin
            dec.tgt = TGT_NONE;
            if (l2_a64_tge)      dec.act = ACT_TRAP_L2;
            else if (l2_a32_tge) dec.act = ACT_HYP;
            else                 dec.act = ACT_UNDEF;
        end else if (host && !usr_en_l2) begin
            dec = '{act: ACT_TRAP_L2, tgt: TGT_NONE};
        end else if (l2_a64_nohost && l1_vt_trap) begin
            dec = '{act: ACT_TRAP_L2, tgt: TGT_NONE};
        end else if (host && !nonsec && sec_l2_impl) begin
            dec.tgt = TGT_HV_SEC;
        end else if (host && nonsec) begin
            dec.tgt = TGT_HV_NS;
        end
    end
endmodule

// File: rtl/ttr_priv_chain.sv
module ttr_priv_chain
    import ttr_pkg::*;
(
    input  logic     is_l1,
    input  logic     l2_a64_on,
    input  logic     l1_vt_trap,
    output ttr_dec_t dec
);
    always_comb begin
        if (is_l1 && l2_a64_on && l1_vt_trap)
            dec = '{act: ACT_TRAP_L2, tgt: TGT_NONE};
        else
            dec = DEC_ALLOW_VIRT;
    end
endmodule

// File: rtl/ttr_out_stage.sv
module ttr_out_stage
    import ttr_pkg::*;
#(
    parameter bit REG_OUT = 1'b1,
    parameter int SYN_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic             in_wr,
    input  ttr_dec_t         in_dec,
    input  logic [SYN_W-1:0] in_syn,
    output logic             out_vld,
    output logic             out_wr,
    output logic [2:0]       out_act,
    output logic [1:0]       out_tgt,
    output logic [SYN_W-1:0] out_syn
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_vld <= 1'b0;
                    out_wr  <= 1'b0;
                    out_act <= ACT_ALLOW;
                    out_tgt <= TGT_NONE;
                    out_syn <= '0;
                end else begin
                    out_vld <= in_vld;
                    out_wr  <= in_wr;
                    out_act <= in_dec.act;
                    out_tgt <= in_dec.tgt;
                    out_syn <= in_syn;
                end
            end
        end else begin : g_comb
            always_comb begin
                out_vld = in_vld && rst_n;
                out_wr  = in_wr;
                out_act = in_dec.act;
                out_tgt = in_dec.tgt;
                out_syn = in_syn;
            end
        end
    endgenerate
endmodule

// File: rtl/ttr_access_router.sv
module ttr_access_router
    import ttr_pkg::*;
#(
    parameter bit          REG_OUT  = 1'b1,
    parameter int          SYN_W    = 8,
    parameter logic [SYN_W-1:0] SYN_TRAP = 'h04,
    parameter logic [SYN_W-1:0] SYN_HYP  = 'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_vld,
    input  logic             req_wr,
    input  logic [1:0]       req_lvl,
    input  logic             l1_aa64,
    input  logic             l2_aa64,
    input  logic             l2_on,
    input  logic             hv_e2h,
    input  logic             hv_tge,
    input  logic             nonsec,
    input  logic             sec_l2_impl,
    input  logic             usr_vt_en_l1a64,
    input  logic             usr_vt_en_l1a32,
    input  logic             usr_vt_en_l2,
    input  logic             l1_vt_trap,
    output logic             rsp_vld,
    output logic             rsp_wr,
    output logic [2:0]       rsp_act,
    output logic [1:0]       rsp_tgt,
    output logic [SYN_W-1:0] rsp_syn
);
    localparam logic [1:0] LVL_USER = 2'd0;
    localparam logic [1:0] LVL_KERN = 2'd1;

    logic     l2_a64_on, host, l2_a64_tge, l2_a32_tge, l2_a64_nohost;
    ttr_dec_t dec_user, dec_priv, dec_sel;
    logic [SYN_W-1:0] syn_sel;

    ttr_mode_decode u_mode (
        .l2_on         (l2_on),
        .l2_aa64       (l2_aa64),
        .hv_e2h        (hv_e2h),
        .hv_tge        (hv_tge),
        .l2_a64_on     (l2_a64_on),
        .host          (host),
        .l2_a64_tge    (l2_a64_tge),
        .l2_a32_tge    (l2_a32_tge),
        .l2_a64_nohost (l2_a64_nohost)
    );

    ttr_user_chain u_user (
        .l1_aa64       (l1_aa64),
        .usr_en_l1a64  (usr_vt_en_l1a64),
        .usr_en_l1a32  (usr_vt_en_l1a32),
        .usr_en_l2     (usr_vt_en_l2),
        .l1_vt_trap    (l1_vt_trap),
        .nonsec        (nonsec),
        .sec_l2_impl   (sec_l2_impl),
        .host          (host),
        .l2_a64_tge    (l2_a64_tge),
        .l2_a32_tge    (l2_a32_tge),
        .l2_a64_nohost (l2_a64_nohost),
        .dec           (dec_user)
    );

    ttr_priv_chain u_priv (
        .is_l1      (req_lvl == LVL_KERN),
        .l2_a64_on  (l2_a64_on),
        .l1_vt_trap (l1_vt_trap),
        .dec        (dec_priv)
    );

    always_comb begin
        dec_sel = (req_lvl == LVL_USER) ? dec_user : dec_priv;
        unique case (dec_sel.act)
            ACT_TRAP_L1, ACT_TRAP_L2: syn_sel = SYN_TRAP;
            ACT_HYP:                  syn_sel = SYN_HYP;
            default:                  syn_sel = '0;
        endcase
    end

    ttr_out_stage #(.REG_OUT(REG_OUT), .SYN_W(SYN_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (req_vld),
        .in_wr   (req_wr),
        .in_dec  (dec_sel),
        .in_syn  (syn_sel),
        .out_vld (rsp_vld),
        .out_wr  (rsp_wr),
        .out_act (rsp_act),
        .out_tgt (rsp_tgt),
        .out_syn (rsp_syn)
    );
endmodule

// File: rtl/ttr_access_router_chk.sv
module ttr_access_router_chk
    import ttr_pkg::*;
#(
    parameter bit          REG_OUT  = 1'b1,
    parameter int          SYN_W    = 8,
    parameter logic [SYN_W-1:0] SYN_TRAP = 'h04
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_vld,
    input logic             req_wr,
    input logic [1:0]       req_lvl,
    input logic             rsp_vld,
    input logic             rsp_wr,
    input logic [2:0]       rsp_act,
    input logic [1:0]       rsp_tgt,
    input logic [SYN_W-1:0] rsp_syn
);
    a_r10_no_target: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld && rsp_act != ACT_ALLOW |-> rsp_tgt == TGT_NONE);
    a_r10_trap_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld && (rsp_act == ACT_TRAP_L1 || rsp_act == ACT_TRAP_L2) |-> rsp_syn == SYN_TRAP);

    generate
        if (REG_OUT) begin : g_seq
            a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
                req_vld |=> rsp_vld);
            a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
                !req_vld |=> !rsp_vld);
            a_r3_high_levels: assert property (@(posedge clk) disable iff (!rst_n)
                req_vld && req_lvl[1] |=> rsp_act == ACT_ALLOW && rsp_tgt == TGT_VIRT);
            a_r4_level1_verdicts: assert property (@(posedge clk) disable iff (!rst_n)
                req_vld && req_lvl == 2'd1 |=> rsp_act == ACT_ALLOW || rsp_act == ACT_TRAP_L2);
            a_r11_dir_echo: assert property (@(posedge clk) disable iff (!rst_n)
                req_vld |=> rsp_wr == $past(req_wr));
        end
    endgenerate
endmodule

bind ttr_access_router ttr_access_router_chk #(
    .REG_OUT(REG_OUT), .SYN_W(SYN_W), .SYN_TRAP(SYN_TRAP)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_vld (req_vld),
    .req_wr  (req_wr),
    .req_lvl (req_lvl),
    .rsp_vld (rsp_vld),
    .rsp_wr  (rsp_wr),
    .rsp_act (rsp_act),
    .rsp_tgt (rsp_tgt),
    .rsp_syn (rsp_syn)
);

// File: tb/ttr_access_router_tb.sv
module ttr_access_router_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_vld = 1'b0, req_wr = 1'b0;
    logic [12:0] vec = '0;
    logic rsp_vld, rsp_wr;
    logic [2:0] rsp_act;
    logic [1:0] rsp_tgt;
    logic [7:0] rsp_syn;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ttr_access_router dut_i (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
        .req_lvl(vec[1:0]), .l1_aa64(vec[2]), .l2_aa64(vec[3]), .l2_on(vec[4]),
        .hv_e2h(vec[5]), .hv_tge(vec[6]), .nonsec(vec[7]), .sec_l2_impl(vec[8]),
        .usr_vt_en_l1a64(vec[9]), .usr_vt_en_l1a32(vec[10]), .usr_vt_en_l2(vec[11]),
        .l1_vt_trap(vec[12]),
        .rsp_vld(rsp_vld), .rsp_wr(rsp_wr), .rsp_act(rsp_act), .rsp_tgt(rsp_tgt),
        .rsp_syn(rsp_syn)
    );

    function automatic logic [12:0] mk(input int lvl, input bit a1, a2, on, e2h, tge,
                                       ns, s2, u1, u32, u2, tr);
        return {tr, u2, u32, u1, s2, ns, tge, e2h, on, a2, a1, 2'(lvl)};
    endfunction

    // Reference model: returns {act, tgt}
    function automatic logic [4:0] ref_dec(input logic [12:0] v);
        logic [1:0] lvl = v[1:0];
        bit a1 = v[2], a2 = v[3], on = v[4], e2h = v[5], tge = v[6], ns = v[7];
        bit s2 = v[8], u1 = v[9], u32 = v[10], u2 = v[11], tr = v[12];
        bit hm = on && a2 && e2h && tge;
        if (lvl >= 2) return {3'd0, 2'd0};
        if (lvl == 1) return (on && a2 && tr) ? {3'd2, 2'd3} : {3'd0, 2'd0};
        if (a1 && !hm && !u1) return (on && a2 && tge) ? {3'd2, 2'd3} : {3'd1, 2'd3};
        if (!a1 && !u32) begin
            if (on && a2 && tge) return {3'd2, 2'd3};
            if (on && !a2 && tge) return {3'd3, 2'd3};
            return {3'd4, 2'd3};
        end
        if (hm && !u2) return {3'd2, 2'd3};
        if (on && a2 && !(e2h && tge) && tr) return {3'd2, 2'd3};
        if (hm && !ns && s2) return {3'd0, 2'd1};
        if (hm && ns) return {3'd0, 2'd2};
        return {3'd0, 2'd0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input string req, input logic [12:0] v, input bit wr,
                         input logic [2:0] ea, input logic [1:0] et);
        logic [7:0] es;
        @(negedge clk);
        vec = v; req_wr = wr; req_vld = 1'b1;
        @(negedge clk);
        es = (ea == 3'd1 || ea == 3'd2) ? 8'h04 : 8'h00;
        check(req, {rsp_vld, rsp_wr, rsp_act, rsp_tgt, rsp_syn},
              {1'b1, wr, ea, et, es});
    endtask

    task automatic t_reset();
        check("R1", {rsp_vld, rsp_act, rsp_tgt, rsp_syn}, {1'b0, 3'd0, 2'd3, 8'h00});
    endtask

    task automatic t_latency();
        apply("R2", mk(2,0,0,0,0,0,0,0,0,0,0,0), 1'b0, 3'd0, 2'd0);
        @(negedge clk); req_vld = 1'b0;
        @(negedge clk);
        check("R2 idle", {31'd0, rsp_vld}, 32'd0);
    endtask

    task automatic t_levels();
        apply("R3", mk(2,0,0,0,0,0,0,0,0,0,0,0), 1'b0, 3'd0, 2'd0);
        apply("R3", mk(3,1,1,1,1,1,1,1,0,0,0,1), 1'b1, 3'd0, 2'd0);
        apply("R4", mk(1,1,1,1,0,0,0,0,0,0,0,1), 1'b0, 3'd2, 2'd3);
        apply("R4", mk(1,1,0,1,0,0,0,0,0,0,0,1), 1'b0, 3'd0, 2'd0);
    endtask

    task automatic t_user_traps();
        apply("R5", mk(0,1,1,1,0,1,0,0,0,1,1,0), 1'b0, 3'd2, 2'd3);
        apply("R5", mk(0,1,0,0,0,0,0,0,0,1,1,0), 1'b1, 3'd1, 2'd3);
        apply("R6", mk(0,0,1,1,0,1,0,0,1,0,1,1), 1'b0, 3'd2, 2'd3);
        apply("R6", mk(0,0,0,1,0,1,0,0,1,0,1,1), 1'b0, 3'd3, 2'd3);
        apply("R6", mk(0,0,0,0,0,1,0,0,1,0,1,1), 1'b0, 3'd4, 2'd3);
        apply("R7", mk(0,1,1,1,1,1,1,0,0,1,0,0), 1'b0, 3'd2, 2'd3);
        apply("R8", mk(0,1,1,1,1,0,0,0,1,1,1,1), 1'b0, 3'd2, 2'd3);
    endtask

    task automatic t_steer();
        apply("R9", mk(0,1,1,1,1,1,0,1,0,1,1,0), 1'b0, 3'd0, 2'd1);
        apply("R9", mk(0,1,1,1,1,1,1,0,0,1,1,0), 1'b0, 3'd0, 2'd2);
        apply("R9", mk(0,1,1,1,1,1,0,0,0,1,1,0), 1'b0, 3'd0, 2'd0);
    endtask

    task automatic t_direction();
        apply("R11 read", mk(0,0,0,1,0,1,0,0,1,0,1,1), 1'b0, 3'd3, 2'd3);
        apply("R11 write", mk(0,0,0,1,0,1,0,0,1,0,1,1), 1'b1, 3'd3, 2'd3);
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 8192; i++) begin
            logic [4:0] e = ref_dec(13'(i));
            apply("R10 sweep", 13'(i), ^13'(i), e[4:2], e[1:0]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_latency();
        t_levels();
        t_user_traps();
        t_steer();
        t_direction();
        t_sweep();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule